// File: doc/BRIEF.md
# Indirect bus access bridge

The bridge lets a host reach an internal 32-bit bus one transaction at a time through four small registers. The host first writes the top address byte into a base register and, for writes, the data into a write-data register. It then writes a command word that carries the direction, the access size as a byte count, and the low 24 address bits. That command write starts exactly one bus access.

The bridge builds the full address from the two registers and raises a request on a simple request/acknowledge master port. It holds the request until the bus acknowledges, or until a fixed number of cycles has passed, in which case it gives up. Byte lanes follow big-endian numbering, so byte offset 0 is bits 31..24. Narrow write data is taken from the low end of the write-data register. Narrow read data is returned right-justified with zeros above it.

A command with an unsupported size code or a misaligned address never reaches the bus and sets a sticky error flag. An abandoned access sets a sticky timeout flag. Both flags stay set until the host clears them.

Top module: `ibb_bridge`

## Requirements
- R1: After reset, busy, errFlag, toFlag and busReq are 0, and every host register (selects 0..3) reads as 0.
- R2: During an access, busAddr equals {base[31:24], cmd[23:0]} and busWe equals cmd bit 31 (1 = write, 0 = read).
- R3: A command write (hostSel 0) while idle with a valid request raises busReq and busy at the next clock edge. The request and the address are held unchanged until the edge at which busAck is seen high, after which both busReq and busy are 0.
- R4: Cmd bits 27..24 hold the size in bytes (1, 2 or 4) and cmd bits 1..0 hold the byte offset. Byte lane k (offset k) sits at bits 31-8k..24-8k and is enabled by busBe[3-k]. The enabled lanes are offsets off..off+size-1. Write data is the low size bytes of the write-data register, with its least significant byte in the highest-numbered lane. Disabled lanes carry zero.
- R5: On an acknowledged read, the read-data register (hostSel 3) takes the enabled lanes right-justified and zero-extended, with the highest-numbered lane as its least significant byte. A write access leaves it unchanged.
- R6: A size code other than 1, 2 or 4 produces no bus request, leaves busy 0 and sets errFlag at the same edge.
- R7: A halfword at an odd offset or a word at a nonzero offset produces no bus request and sets errFlag.
- R8: If busAck has not been seen after 256 cycles of busReq high, the bridge drops busReq and busy and sets toFlag. Busy therefore stays high for exactly 256 cycles, and the read-data register is not changed.
- R9: A command write while busy is ignored: the address on the bus and the command readback stay as they were.
- R10: errFlag and toFlag stay set through later accesses. Writing hostSel 3 clears errFlag when data bit 0 is 1 and clears toFlag when data bit 1 is 1. Each bit affects only its own flag.
- R11: The base register reads back bits 31..24 with zeros below them. The write-data and command registers read back in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWe | input | 1 | Host register write strobe |
| hostSel | input | 2 | Register select: 0 command, 1 base, 2 write data, 3 read data / flag clear |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Readback of the selected register |
| busy | output | 1 | Access in flight |
| errFlag | output | 1 | Sticky invalid-request flag |
| toFlag | output | 1 | Sticky timeout flag |
| busReq | output | 1 | Bus request, held until acknowledged or abandoned |
| busWe | output | 1 | Bus direction, 1 = write |
| busAddr | output | 32 | Bus address |
| busBe | output | 4 | Byte enables, bit 3 = bits 31..24 |
| busWdata | output | 32 | Bus write data |
| busAck | input | 1 | Bus acknowledge |
| busRdata | input | 32 | Bus read data, valid with busAck |

## Verification
The request, address, enables and write data are due one edge after the command write, so the bench checks them at the falling edge that follows that write. For a valid request, busy and busReq drop at the acknowledging edge, and the read-data register shows the captured value at the next falling edge. An invalid request shows errFlag at the falling edge right after the command write, with busReq still low. For the timeout, the bench counts the falling edges at which busy is high and expects exactly 256.

// File: rtl/ibb_pkg.sv
package ibb_pkg;

  localparam int BYTE_LANES = 4;

  typedef enum logic [1:0] {
    SEL_CMD   = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_WDATA = 2'd2,
    SEL_RDATA = 2'd3
  } regSel_e;

  typedef struct packed {
    logic loadCmd;
    logic loadBase;
    logic loadWdata;
    logic capture;
  } ctrlStrobe_t;

  // Size code is a byte count; alignment follows the size.
  function automatic logic accessOk(input logic [3:0] sizeCode, input logic [1:0] offset);
    case (sizeCode)
      4'd1:    accessOk = 1'b1;
      4'd2:    accessOk = (offset[0] == 1'b0);
      4'd4:    accessOk = (offset == 2'd0);
      default: accessOk = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ibb_ctrl.sv
module ibb_ctrl
  import ibb_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWe,
  input  logic [1:0]  hostSel,
  input  logic [3:0]  cmdSize,
  input  logic [1:0]  cmdOffset,
  input  logic [1:0]  clrBits,
  input  logic        curIsWrite,
  input  logic        busAck,
  output ctrlStrobe_t strobes,
  output logic        busy,
  output logic        errFlag,
  output logic        toFlag
);

  localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(TIMEOUT_CYCLES - 1);

  logic             busyQ;
  logic [CNT_W-1:0] waitCnt;
  logic             cmdHit;
  logic             accept;
  logic             reqOk;
  logic             ackSeen;
  logic             expire;
  logic             clrHit;

  assign cmdHit  = hostWe && (hostSel == 2'(SEL_CMD));
  assign accept  = cmdHit && !busyQ;
  assign reqOk   = accessOk(cmdSize, cmdOffset);
  assign ackSeen = busyQ && busAck;
  assign expire  = busyQ && !busAck && (waitCnt == LAST_WAIT);
  assign clrHit  = hostWe && (hostSel == 2'(SEL_RDATA));

  always_comb begin
    strobes.loadCmd   = accept;
    strobes.loadBase  = hostWe && (hostSel == 2'(SEL_BASE));
    strobes.loadWdata = hostWe && (hostSel == 2'(SEL_WDATA));
    strobes.capture   = ackSeen && !curIsWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      waitCnt <= '0;
    end else if (busyQ) begin
      if (ackSeen || expire) begin
        busyQ   <= 1'b0;
        waitCnt <= '0;
      end else begin
        waitCnt <= waitCnt + 1'b1;
      end
    end else if (accept && reqOk) begin
      busyQ   <= 1'b1;
      waitCnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      toFlag  <= 1'b0;
    end else begin
      if (accept && !reqOk)          errFlag <= 1'b1;
      else if (clrHit && clrBits[0]) errFlag <= 1'b0;
      if (expire)                    toFlag  <= 1'b1;
      else if (clrHit && clrBits[1]) toFlag  <= 1'b0;
    end
  end

  assign busy = busyQ;

endmodule

// File: rtl/ibb_datapath.sv
module ibb_datapath
  import ibb_pkg::*;
#(
  parameter int LOW_ADDR_W = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobes,
  input  logic [1:0]  hostSel,
  input  logic [31:0] hostWdata,
  input  logic [31:0] busRdata,
  output logic [31:0] hostRdata,
  output logic [3:0]  cmdSize,
  output logic [1:0]  cmdOffset,
  output logic        curIsWrite,
  output logic [31:0] busAddr,
  output logic [3:0]  busBe,
  output logic [31:0] busWdata
);

  localparam int HIGH_W = 32 - LOW_ADDR_W;

  logic [31:0]       cmdReg;
  logic [HIGH_W-1:0] baseReg;
  logic [31:0]       wdataReg;
  logic [31:0]       rdataReg;
  logic [31:0]       rdAligned;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      baseReg  <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
    end else begin
      if (strobes.loadCmd)   cmdReg   <= hostWdata;
      if (strobes.loadBase)  baseReg  <= hostWdata[31 -: HIGH_W];
      if (strobes.loadWdata) wdataReg <= hostWdata;
      if (strobes.capture)   rdataReg <= rdAligned;
    end
  end

  assign cmdSize    = cmdReg[27:24];
  assign cmdOffset  = cmdReg[1:0];
  assign curIsWrite = cmdReg[31];
  assign busAddr    = {baseReg, cmdReg[LOW_ADDR_W-1:0]};

  // Outgoing lanes: lane k is offset k, bits 31-8k downward.
  for (genvar lane = 0; lane < BYTE_LANES; lane++) begin : g_wlane
    logic       laneOn;
    logic [7:0] laneByte;
    always_comb begin
      int rel;
      int src;
      rel      = lane - int'(cmdOffset);
      src      = int'(cmdSize) - 1 - rel;
      laneOn   = (rel >= 0) && (rel < int'(cmdSize));
      laneByte = 8'h00;
      if (laneOn && src >= 0 && src < BYTE_LANES) laneByte = wdataReg[8*src +: 8];
    end
    assign busBe[BYTE_LANES-1-lane]   = laneOn;
    assign busWdata[31-8*lane -: 8]   = laneByte;
  end

  // Incoming bytes: result byte j comes from lane offset+size-1-j.
  for (genvar j = 0; j < BYTE_LANES; j++) begin : g_rbyte
    logic [7:0] outByte;
    always_comb begin
      int lane;
      lane    = int'(cmdOffset) + int'(cmdSize) - 1 - j;
      outByte = 8'h00;
      if (j < int'(cmdSize) && lane >= 0 && lane < BYTE_LANES) outByte = busRdata[31-8*lane -: 8];
    end
    assign rdAligned[8*j +: 8] = outByte;
  end

  always_comb begin
    case (hostSel)
      2'(SEL_CMD):   hostRdata = cmdReg;
      2'(SEL_BASE):  hostRdata = {baseReg, {LOW_ADDR_W{1'b0}}};
      2'(SEL_WDATA): hostRdata = wdataReg;
      default:       hostRdata = rdataReg;
    endcase
  end

endmodule

// File: rtl/ibb_bridge.sv
module ibb_bridge
  import ibb_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 256,
  parameter int LOW_ADDR_W     = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWe,
  input  logic [1:0]  hostSel,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        busy,
  output logic        errFlag,
  output logic        toFlag,
  output logic        busReq,
  output logic        busWe,
  output logic [31:0] busAddr,
  output logic [3:0]  busBe,
  output logic [31:0] busWdata,
  input  logic        busAck,
  input  logic [31:0] busRdata
);

  ctrlStrobe_t strobes;
  logic [3:0]  cmdSize;
  logic [1:0]  cmdOffset;
  logic        curIsWrite;

  ibb_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostWe     (hostWe),
    .hostSel    (hostSel),
    .cmdSize    (hostWdata[27:24]),
    .cmdOffset  (hostWdata[1:0]),
    .clrBits    (hostWdata[1:0]),
    .curIsWrite (curIsWrite),
    .busAck     (busAck),
    .strobes    (strobes),
    .busy       (busy),
    .errFlag    (errFlag),
    .toFlag     (toFlag)
  );

  ibb_datapath #(.LOW_ADDR_W(LOW_ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .hostSel    (hostSel),
    .hostWdata  (hostWdata),
    .busRdata   (busRdata),
    .hostRdata  (hostRdata),
    .cmdSize    (cmdSize),
    .cmdOffset  (cmdOffset),
    .curIsWrite (curIsWrite),
    .busAddr    (busAddr),
    .busBe      (busBe),
    .busWdata   (busWdata)
  );

  assign busReq = busy;
  assign busWe  = curIsWrite;

endmodule

// File: rtl/ibb_checker.sv
module ibb_checker #(
  parameter int TIMEOUT_CYCLES = 256
) (
  input logic        clk,
  input logic        rstN,
  input logic        hostWe,
  input logic [1:0]  hostSel,
  input logic [31:0] hostWdata,
  input logic        errFlag,
  input logic        toFlag,
  input logic        busReq,
  input logic [31:0] busAddr,
  input logic [3:0]  busBe,
  input logic        busAck
);

  int reqCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       reqCnt <= 0;
    else if (busReq) reqCnt <= reqCnt + 1;
    else             reqCnt <= 0;
  end

  // R3: address held while the request stays up
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && $past(busReq) && $past(rstN)) |-> $stable(busAddr));

  // R3: request ends at the acknowledging edge
  p_drop_on_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAck) |=> !busReq);

  // R4: enables form one of the legal contiguous patterns
  p_be_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busBe inside {4'b1000, 4'b0100, 4'b0010, 4'b0001, 4'b1100, 4'b0011, 4'b1111}));

  // R6/R7: a rejected command never raises a request
  p_err_no_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !busReq);

  // R8: timeout only ends a pending request
  p_timeout_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toFlag) |-> (!busReq && $past(busReq)));

  // R8: a request never outlives the window
  p_req_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (reqCnt < TIMEOUT_CYCLES));

  // R10: error flag holds unless cleared through select 3 bit 0
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(hostWe && hostSel == 2'd3 && hostWdata[0])) |=> errFlag);

endmodule

bind ibb_bridge ibb_checker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostWe    (hostWe),
  .hostSel   (hostSel),
  .hostWdata (hostWdata),
  .errFlag   (errFlag),
  .toFlag    (toFlag),
  .busReq    (busReq),
  .busAddr   (busAddr),
  .busBe     (busBe),
  .busAck    (busAck)
);

// File: tb/ibb_bridge_tb.sv
`timescale 1ns/1ps
module ibb_bridge_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        busy, errFlag, toFlag, busReq, busWe;
  logic [31:0] busAddr, busWdata;
  logic [3:0]  busBe;
  logic        busAck = 1'b0;
  logic [31:0] busRdata = '0;

  int checks = 0;
  int failures = 0;
  logic [31:0] expRdata = '0;

  always #2 clk = ~clk;

  ibb_bridge u_dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .busy(busy),
    .errFlag(errFlag), .toFlag(toFlag), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    hostWe = 1'b1; hostSel = sel; hostWdata = data;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [31:0] val);
    hostSel = sel;
    #0.1;
    val = hostRdata;
  endtask

  task automatic ackWith(input logic [31:0] data);
    busAck = 1'b1; busRdata = data;
    @(negedge clk);
    busAck = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 errFlag", {31'b0, errFlag}, 0);
    chk("R1 toFlag", {31'b0, toFlag}, 0);
    chk("R1 busReq", {31'b0, busReq}, 0);
    for (int s = 0; s < 4; s++) begin
      readReg(2'(s), v);
      chk("R1 register readback", v, 0);
    end

    // R11 readback of base and write data
    hostWrite(2'd1, 32'h5AFF_FFFF);
    readReg(2'd1, v); chk("R11 base readback", v, 32'h5A00_0000);
    hostWrite(2'd2, 32'hDEAD_BEEF);
    readReg(2'd2, v); chk("R11 wdata readback", v, 32'hDEAD_BEEF);

    // Sweep: direction x size code x offset
    for (int op = 0; op < 2; op++) begin
      for (int sz = 0; sz < 16; sz++) begin
        for (int off = 0; off < 4; off++) begin
          automatic int it = op*64 + sz*4 + off;
          automatic logic [7:0]  base = 8'(8'h11 + it*7);
          automatic logic [31:0] wd = 32'h8192_A3B4 ^ (it * 32'h0101_0305);
          automatic logic [31:0] rd = 32'hC1D2_E3F4 ^ (it * 32'h0703_0201);
          automatic logic [23:0] low = 24'h3C5A00 ^ 24'(it << 8) | 24'(off);
          automatic logic [31:0] cmd = {1'(op), 3'b0, 4'(sz), low};
          automatic bit ok = (sz == 1) || (sz == 2 && off % 2 == 0) || (sz == 4 && off == 0);
          automatic int lat = it % 4;
          hostWrite(2'd1, {base, 24'h0});
          hostWrite(2'd2, wd);
          hostWrite(2'd0, cmd);
          if (ok) begin
            automatic int sh = 8 * (4 - sz - off);
            automatic logic [31:0] mask = (sz == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*sz)) - 1);
            automatic logic [3:0] be = 4'(((1 << sz) - 1) << (4 - sz - off));
            chk("R3 busReq raised", {31'b0, busReq}, 1);
            chk("R3 busy raised", {31'b0, busy}, 1);
            chk("R2 busAddr", busAddr, {base, low});
            chk("R2 busWe", {31'b0, busWe}, 32'(op));
            chk("R4 busBe", {28'b0, busBe}, {28'b0, be});
            if (op == 1) chk("R4 busWdata", busWdata, (wd & mask) << sh);
            for (int k = 0; k < lat; k++) begin
              @(negedge clk);
              chk("R3 request held", {31'b0, busReq}, 1);
              chk("R3 address held", busAddr, {base, low});
            end
            ackWith(rd);
            chk("R3 busReq after ack", {31'b0, busReq}, 0);
            chk("R3 busy after ack", {31'b0, busy}, 0);
            if (op == 0) expRdata = (rd >> sh) & mask;
            readReg(2'd3, v);
            chk(op == 0 ? "R5 read data aligned" : "R5 write leaves read data", v, expRdata);
            chk("R6 no error on valid", {31'b0, errFlag}, 0);
          end else begin
            chk(sz inside {1, 2, 4} ? "R7 misaligned no request" : "R6 bad size no request",
                {31'b0, busReq}, 0);
            chk("R6 busy stays low", {31'b0, busy}, 0);
            chk(sz inside {1, 2, 4} ? "R7 errFlag set" : "R6 errFlag set", {31'b0, errFlag}, 1);
            @(negedge clk);
            chk("R6 still no request", {31'b0, busReq}, 0);
            readReg(2'd3, v);
            chk("R6 read data unchanged", v, expRdata);
            hostWrite(2'd3, 32'h1);
            chk("R10 errFlag cleared", {31'b0, errFlag}, 0);
          end
        end
      end
    end

    // R9 command ignored while busy
    hostWrite(2'd1, 32'hA500_0000);
    hostWrite(2'd0, 32'h0400_1234);
    hostWrite(2'd0, 32'h8100_5679);
    chk("R9 address unchanged", busAddr, 32'hA500_1234);
    readReg(2'd0, v); chk("R9 command readback unchanged", v, 32'h0400_1234);
    chk("R9 no error from ignored write", {31'b0, errFlag}, 0);
    ackWith(32'h0BAD_F00D);
    readReg(2'd3, v); chk("R5 word read", v, 32'h0BAD_F00D);
    expRdata = 32'h0BAD_F00D;

    // R8 timeout
    hostWrite(2'd0, 32'h0200_0002);
    n = 0;
    while (busy && n < 400) begin n++; @(negedge clk); end
    chk("R8 busy cycles", 32'(n), 256);
    chk("R8 toFlag set", {31'b0, toFlag}, 1);
    chk("R8 busReq dropped", {31'b0, busReq}, 0);
    readReg(2'd3, v); chk("R8 read data unchanged", v, expRdata);

    // R10 sticky through a good access, selective clear
    hostWrite(2'd0, 32'h0100_0003);
    ackWith(32'h0000_0077);
    chk("R10 toFlag sticky", {31'b0, toFlag}, 1);
    readReg(2'd3, v); chk("R5 byte read offset 3", v, 32'h77);
    hostWrite(2'd0, 32'h0300_0000);
    chk("R10 errFlag set", {31'b0, errFlag}, 1);
    hostWrite(2'd3, 32'h1);
    chk("R10 bit0 clears errFlag", {31'b0, errFlag}, 0);
    chk("R10 bit0 keeps toFlag", {31'b0, toFlag}, 1);
    hostWrite(2'd3, 32'h2);
    chk("R10 bit1 clears toFlag", {31'b0, toFlag}, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule